// File: doc/BRIEF.md
# Transmit Timing Source Selector

This block picks the timing reference for a framer's transmit path. Three candidate tick streams arrive as one-cycle enable pulses in the single system clock domain: recovered receive-line timing, ticks from the transmit serial clock pin, and ticks from an internal divided oscillator. A two-bit select code names the wanted source. While the recovered timing is the wanted source, a watchdog on it falls back to the oscillator automatically when that timing disappears. The selected stream leaves the block as the transmit tick.

A frame counter runs on the transmit tick. It produces a frame sync pulse and a multiframe sync pulse. The block also drives the output-enable controls for the frame sync, multiframe sync and serial clock pins. These controls depend on the backplane mode input and on the select code. When the pins are inputs, external sync pulses realign the counters. A status port reports the source actually in use after failover. A sticky loss flag records any loss of recovered timing.

All ports are plain control and status signals. There is no valid/ready stream and no back-pressure: every tick pulse is a single-cycle event that is consumed in the cycle it occurs.

Top module: `tx_timing_sel`

## Requirements
- R1: The select code maps to sources as 00 = recovered, 01 = serial pin, 10 = oscillator, and 11 behaves exactly like 00. The status port `src_used_o` uses the same code values: 00 recovered, 01 serial, 10 oscillator.
- R2: With select 00, 10 or 11, the oscillator is used while recovered timing is lost. With select 01, the serial source stays in use even when recovered timing is lost.
- R3: Loss of recovered timing (`rec_lost_o` = 1) is declared after `LOS_WIN` (default 64) consecutive system cycles with no recovered tick, and not before.
- R4: Loss clears after `CLR_CNT` (default 8) recovered ticks in a row, each arriving within `LOS_WIN` cycles of the one before.
- R5: All three output enables are 1 when `bp_nomux_2m_i` = 1 and the select code is not 01. They are 0 in every other combination.
- R6: `tx_tick_o` reproduces the in-use source's tick one system cycle later.
- R7: A change of source takes effect only at a tick of the new source. That switching tick is withheld if `tx_tick_o` was high in the cycle before, so the output never shows two adjacent high cycles from a switch.
- R8: `fr_sync_o` is high on every 256th transmit tick. `mf_sync_o` is high on every 4096th. Both are high on the first tick after reset, and `mf_sync_o` only ever coincides with `fr_sync_o`.
- R9: While the pins are inputs (enables 0), a transmit tick with `ext_fr_sync_i` high is taken as bit 0 of a frame, and `ext_mf_sync_i` high additionally makes it frame 0. While the pins are outputs, both inputs have no effect.
- R10: `los_sticky_o` is set one cycle after loss is declared and is cleared by a one-cycle `los_clr_i` pulse. A new loss takes priority over a clear in the same cycle.
- R11: The oscillator ticks once every `OSC_RELOAD`+1 system cycles (default 4), continuously and regardless of the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_i | input | 2 | Timing source select code |
| bp_nomux_2m_i | input | 1 | 1 = non-multiplexed 2.048 MHz backplane mode |
| rec_tick_i | input | 1 | Recovered receive-line tick pulse |
| ser_tick_i | input | 1 | Transmit serial clock pin tick pulse |
| ext_fr_sync_i | input | 1 | External frame sync from the pin |
| ext_mf_sync_i | input | 1 | External multiframe sync from the pin |
| los_clr_i | input | 1 | Write-one pulse clearing the sticky loss flag |
| tx_tick_o | output | 1 | Selected transmit tick |
| fr_sync_o | output | 1 | Frame sync, one tick wide |
| mf_sync_o | output | 1 | Multiframe sync, one tick wide |
| fr_sync_oe_o | output | 1 | Output enable for the frame sync pin |
| mf_sync_oe_o | output | 1 | Output enable for the multiframe sync pin |
| serclk_oe_o | output | 1 | Output enable for the serial clock pin |
| src_used_o | output | 2 | Source actually in use, after failover |
| rec_lost_o | output | 1 | Recovered timing currently lost |
| los_sticky_o | output | 1 | Sticky record of a loss event |

## Verification
The bench probes the loss window from both sides. It checks that the source still reads 00 after 50 idle cycles and has become the oscillator after 90. An off-by-a-window detector would fail over early or too late. During recovery it samples after only six fresh ticks and again after a dozen, to catch a detector that clears on the first tick or never clears. With select 01 and the recovered timing removed, it confirms that no failover occurs. It also counts every pair of adjacent high `tx_tick_o` cycles and compares each tick's position against 256- and 4096-tick expectations across a mode change. A switch that lets old and new ticks merge, or that wrongly accepts or ignores external sync, shows up as a count mismatch.

// File: rtl/tts_pkg.sv
package tts_pkg;

  typedef enum logic [1:0] {
    SRC_REC = 2'b00,
    SRC_SER = 2'b01,
    SRC_OSC = 2'b10
  } src_e;

  // Resolve the requested code and the loss state to the wanted source.
  function automatic src_e resolve_src(input logic [1:0] code, input logic lost);
    if (code == 2'b01) return SRC_SER;
    if (code == 2'b10) return SRC_OSC;
    return lost ? SRC_OSC : SRC_REC;
  endfunction

  // All pins become outputs only in the non-multiplexed mode with a non-serial code.
  function automatic logic pins_driven(input logic [1:0] code, input logic nomux);
    return nomux && (code != 2'b01);
  endfunction

endpackage

// File: rtl/tts_osc_div.sv
module tts_osc_div #(
  parameter int OSC_RELOAD = 3
) (
  input  logic clk,
  input  logic rst_n,
  output logic osc_tick
);
  localparam int OW = (OSC_RELOAD < 1) ? 1 : $clog2(OSC_RELOAD + 1);

  logic [OW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= OW'(OSC_RELOAD);
      osc_tick <= 1'b0;
    end else begin
      osc_tick <= (cnt_q == '0);
      cnt_q    <= (cnt_q == '0) ? OW'(OSC_RELOAD) : cnt_q - 1'b1;
    end
  end

  // R11: with a reload of at least one, ticks are never adjacent
  assert_osc_spacing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    osc_tick |=> !osc_tick);

endmodule

// File: rtl/tts_loss_mon.sv
module tts_loss_mon #(
  parameter int LOS_WIN = 64,
  parameter int CLR_CNT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rec_tick,
  output logic lost
);
  localparam int GW = $clog2(LOS_WIN);
  localparam int CW = (CLR_CNT < 2) ? 1 : $clog2(CLR_CNT);

  logic [GW-1:0] gap_q;
  logic [CW-1:0] good_q;
  logic          expire;

  assign expire = !rec_tick && (gap_q == GW'(LOS_WIN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      good_q <= '0;
      lost   <= 1'b0;
    end else begin
      if (rec_tick)    gap_q <= '0;
      else if (!expire) gap_q <= gap_q + 1'b1;

      if (expire) begin
        lost   <= 1'b1;
        good_q <= '0;
      end else if (lost && rec_tick) begin
        if (good_q == CW'(CLR_CNT - 1)) begin
          lost   <= 1'b0;
          good_q <= '0;
        end else begin
          good_q <= good_q + 1'b1;
        end
      end
    end
  end

  // R3: loss is only ever declared in a cycle with no recovered tick
  assert_loss_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |-> !$past(rec_tick));

  // R4: loss clears only on a recovered tick
  assert_clear_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost) |-> $past(rec_tick));

endmodule

// File: rtl/tts_switch.sv
module tts_switch
  import tts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] tick_vec,
  input  src_e       want,
  output src_e       cur,
  output logic       tx_tick
);
  logic take_new;
  logic nxt_tick;

  always_comb begin
    take_new = (want != cur) && tick_vec[want] && !tx_tick;
    nxt_tick = take_new ? 1'b1 : tick_vec[cur];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= SRC_REC;
      tx_tick <= 1'b0;
    end else begin
      tx_tick <= nxt_tick;
      if (take_new) cur <= want;
    end
  end

  // R7: every change of source is marked by a tick of the new source
  assert_switch_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != $past(cur)) |-> tx_tick);

  // R7: a switching tick never follows a tick in the previous cycle
  assert_no_stretch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cur != $past(cur)) |-> !$past(tx_tick));

endmodule

// File: rtl/tts_frame_gen.sv
module tts_frame_gen #(
  parameter int BITS_PER_FRAME = 256,
  parameter int FRAMES_PER_MF  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pins_in,
  input  logic ext_fr,
  input  logic ext_mf,
  output logic fr_sync,
  output logic mf_sync
);
  localparam int BW = $clog2(BITS_PER_FRAME);
  localparam int FW = $clog2(FRAMES_PER_MF);

  logic [BW-1:0] bit_q;
  logic [FW-1:0] frm_q;
  logic          realign;

  assign fr_sync = tick && (bit_q == '0);
  assign mf_sync = fr_sync && (frm_q == '0);
  assign realign = pins_in && (ext_fr || ext_mf);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q <= '0;
      frm_q <= '0;
    end else if (tick) begin
      if (realign) begin
        bit_q <= BW'(1);
        if (ext_mf) frm_q <= '0;
      end else if (bit_q == BW'(BITS_PER_FRAME - 1)) begin
        bit_q <= '0;
        frm_q <= (frm_q == FW'(FRAMES_PER_MF - 1)) ? '0 : frm_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  // R8: a multiframe sync is always also a frame sync
  assert_mf_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mf_sync |-> fr_sync);

  // R9: a realigning tick puts the next tick at bit one
  assert_realign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && realign) |=> (bit_q == BW'(1)));

endmodule

// File: rtl/tx_timing_sel.sv
module tx_timing_sel
  import tts_pkg::*;
#(
  parameter int LOS_WIN        = 64,
  parameter int CLR_CNT        = 8,
  parameter int OSC_RELOAD     = 3,
  parameter int BITS_PER_FRAME = 256,
  parameter int FRAMES_PER_MF  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel_i,
  input  logic       bp_nomux_2m_i,
  input  logic       rec_tick_i,
  input  logic       ser_tick_i,
  input  logic       ext_fr_sync_i,
  input  logic       ext_mf_sync_i,
  input  logic       los_clr_i,
  output logic       tx_tick_o,
  output logic       fr_sync_o,
  output logic       mf_sync_o,
  output logic       fr_sync_oe_o,
  output logic       mf_sync_oe_o,
  output logic       serclk_oe_o,
  output logic [1:0] src_used_o,
  output logic       rec_lost_o,
  output logic       los_sticky_o
);
  logic osc_tick;
  logic lost;
  logic lost_prev;
  logic drive;
  src_e want;
  src_e cur;

  tts_osc_div #(.OSC_RELOAD(OSC_RELOAD)) u_osc (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick)
  );

  tts_loss_mon #(.LOS_WIN(LOS_WIN), .CLR_CNT(CLR_CNT)) u_loss (
    .clk(clk), .rst_n(rst_n), .rec_tick(rec_tick_i), .lost(lost)
  );

  assign want  = resolve_src(sel_i, lost);
  assign drive = pins_driven(sel_i, bp_nomux_2m_i);

  tts_switch u_sw (
    .clk(clk), .rst_n(rst_n),
    .tick_vec({1'b0, osc_tick, ser_tick_i, rec_tick_i}),
    .want(want), .cur(cur), .tx_tick(tx_tick_o)
  );

  tts_frame_gen #(.BITS_PER_FRAME(BITS_PER_FRAME), .FRAMES_PER_MF(FRAMES_PER_MF)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(tx_tick_o), .pins_in(!drive),
    .ext_fr(ext_fr_sync_i), .ext_mf(ext_mf_sync_i),
    .fr_sync(fr_sync_o), .mf_sync(mf_sync_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lost_prev    <= 1'b0;
      los_sticky_o <= 1'b0;
    end else begin
      lost_prev    <= lost;
      los_sticky_o <= (lost && !lost_prev) || (los_sticky_o && !los_clr_i);
    end
  end

  assign fr_sync_oe_o = drive;
  assign mf_sync_oe_o = drive;
  assign serclk_oe_o  = drive;
  assign src_used_o   = cur;
  assign rec_lost_o   = lost;

  // R10: a declared loss always lands in the sticky flag
  assert_sticky_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost) |=> los_sticky_o);

  // R5: pins are never driven outside the non-multiplexed mode
  assert_oe_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    serclk_oe_o |-> bp_nomux_2m_i);

  // R2: the serial code never ends up on the oscillator after a switch
  assert_ser_no_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i == 2'b01 && $past(sel_i) == 2'b01 && cur != $past(cur)) |-> (cur == SRC_SER));

endmodule

// File: tb/tb_tx_timing_sel.sv
module tb_tx_timing_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       bp_mode = 1'b0;
  logic       rec_tick = 1'b0, ser_tick = 1'b0;
  logic       ext_fr = 1'b0, ext_mf = 1'b0, los_clr = 1'b0;
  logic       tx_tick, fr_sync, mf_sync, fr_oe, mf_oe, ser_oe, rec_lost, los_sticky;
  logic [1:0] src_used;
  logic       rec_en = 1'b0, ser_en = 1'b0;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  tx_timing_sel dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .bp_nomux_2m_i(bp_mode),
    .rec_tick_i(rec_tick), .ser_tick_i(ser_tick),
    .ext_fr_sync_i(ext_fr), .ext_mf_sync_i(ext_mf), .los_clr_i(los_clr),
    .tx_tick_o(tx_tick), .fr_sync_o(fr_sync), .mf_sync_o(mf_sync),
    .fr_sync_oe_o(fr_oe), .mf_sync_oe_o(mf_oe), .serclk_oe_o(ser_oe),
    .src_used_o(src_used), .rec_lost_o(rec_lost), .los_sticky_o(los_sticky)
  );

  // tick generators: recovered every 5 cycles, serial every 7
  initial begin
    int rc = 0;
    forever begin
      @(posedge clk); #1;
      rc = (rc == 4) ? 0 : rc + 1;
      rec_tick = rec_en && (rc == 0);
    end
  end
  initial begin
    int sc = 0;
    forever begin
      @(posedge clk); #1;
      sc = (sc == 6) ? 0 : sc + 1;
      ser_tick = ser_en && (sc == 0);
    end
  end

  // source-following and stretch monitor
  int cmp_sel = 0, mism = 0, matched = 0, stretch = 0;
  logic prev_rec = 0, prev_ser = 0, prev_tx = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_tx = 0;
    end else begin
      if (cmp_sel == 1 && tx_tick !== prev_rec) mism++;
      if (cmp_sel == 2 && tx_tick !== prev_ser) mism++;
      if (cmp_sel != 0 && tx_tick) matched++;
      if (tx_tick && prev_tx) stretch++;
      prev_tx = tx_tick;
    end
    prev_rec = rec_tick;
    prev_ser = ser_tick;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // {sel[1:0], backplane mode, expected enable}
  localparam logic [3:0] OE_TAB [8] = '{
    4'b00_0_0, 4'b00_1_1, 4'b01_0_0, 4'b01_1_0,
    4'b10_0_0, 4'b10_1_1, 4'b11_0_0, 4'b11_1_1
  };

  initial begin
    int m0, x0, s0;
    int idx, base, gap, fmis, gapbad, mfseen;
    logic efr, emf;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // reset state
    chk("R1 reset src", src_used, 0);
    chk("R6 reset tick", tx_tick, 0);
    chk("R10 reset sticky", los_sticky, 0);
    chk("R3 reset lost", rec_lost, 0);
    #1 rst_n = 1'b1;

    // R5: output-enable table
    for (int i = 0; i < 8; i++) begin
      sel = OE_TAB[i][3:2];
      bp_mode = OE_TAB[i][1];
      @(negedge clk);
      chk("R5 fr oe", fr_oe, OE_TAB[i][0]);
      chk("R5 mf oe", mf_oe, OE_TAB[i][0]);
      chk("R5 ser oe", ser_oe, OE_TAB[i][0]);
    end

    // frame counting on the oscillator (R8, R9, R11)
    sel = 2'b10; bp_mode = 1'b1;
    do_reset();
    idx = 0; base = 0; gap = 0; fmis = 0; gapbad = 0; mfseen = 0;
    while (idx < 12500) begin
      @(negedge clk);
      ext_fr = 1'b0; ext_mf = 1'b0;
      if (tx_tick) begin
        efr = ((idx - base) % 256) == 0;
        emf = ((idx - base) % 4096) == 0;
        if (fr_sync !== efr || mf_sync !== emf) fmis++;
        if (mf_sync) mfseen++;
        if (idx > 0 && gap != 4) gapbad++;
        gap = 0;
        if (idx == 100) ext_fr = 1'b1;          // pins are outputs: ignored
        if (idx == 8300) begin                   // pins become inputs: realign
          bp_mode = 1'b0; ext_fr = 1'b1; ext_mf = 1'b1; base = 8300;
        end
        idx++;
      end
      gap++;
    end
    chk("R8 R9 sync position mismatches", fmis, 0);
    chk("R8 R9 multiframe pulses", mfseen, 4);
    chk("R11 oscillator spacing errors", gapbad, 0);

    // recovered source and select decode
    sel = 2'b00; bp_mode = 1'b1; rec_en = 1'b1;
    do_reset();
    wait_cyc(100);
    chk("R1 code 00 recovered", src_used, 0);
    m0 = mism; x0 = matched; cmp_sel = 1;
    wait_cyc(200);
    cmp_sel = 0;
    chk("R6 follows recovered", mism - m0, 0);
    chk("R6 recovered ticks seen", (matched - x0) > 30, 1);
    sel = 2'b11; wait_cyc(20);
    chk("R1 code 11 like 00", src_used, 0);
    sel = 2'b10; wait_cyc(20);
    chk("R1 code 10 oscillator", src_used, 2);
    sel = 2'b00; wait_cyc(20);
    chk("R7 back to recovered", src_used, 0);

    // loss window and failover
    rec_en = 1'b0;
    wait_cyc(50);
    chk("R3 not lost early", rec_lost, 0);
    chk("R2 still recovered", src_used, 0);
    wait_cyc(40);
    chk("R3 lost declared", rec_lost, 1);
    chk("R2 failover to oscillator", src_used, 2);
    chk("R10 sticky set", los_sticky, 1);

    // recovery
    rec_en = 1'b1;
    wait_cyc(30);
    chk("R4 not cleared after few ticks", src_used, 2);
    wait_cyc(40);
    chk("R4 recovered again", rec_lost, 0);
    chk("R4 source restored", src_used, 0);
    chk("R10 sticky holds", los_sticky, 1);
    los_clr = 1'b1; @(posedge clk); #1 los_clr = 1'b0;
    @(negedge clk);
    chk("R10 sticky cleared", los_sticky, 0);

    // serial select: no failover
    sel = 2'b01; ser_en = 1'b1; rec_en = 1'b0;
    wait_cyc(150);
    chk("R2 serial kept while lost", src_used, 1);
    chk("R10 sticky on new loss", los_sticky, 1);
    chk("R5 serial select pins input", fr_oe, 0);
    s0 = mism; x0 = matched; cmp_sel = 2;
    wait_cyc(200);
    cmp_sel = 0;
    chk("R6 follows serial", mism - s0, 0);
    chk("R6 serial ticks seen", (matched - x0) > 20, 1);
    chk("R7 adjacent tick pairs", stretch, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule